// File: doc/BRIEF.md
# Programmable-Format UART Transceiver

This block is a full-duplex asynchronous serial transceiver. A shared divider produces a tick every `cfg_div + 1` clocks, and each bit lasts 16 ticks. The host sets the character format on static configuration pins: 5 to 9 data bits, one of five parity modes, 1, 1.5 or 2 stop bits, and LSB-first or MSB-first order. A one-cycle write strobe starts a character on `txd`. A received character is held in `rx_data` with `rx_valid` set until the host reads it with a one-cycle strobe.

The receiver waits for a falling edge on the synchronised line. It takes three samples around the middle of each bit and keeps the majority value. It then checks parity and the first stop bit. Parity, framing and overrun errors set sticky flags, as does a detected line break, and one clear strobe resets all four. The transmitter can also hold the line low for as long as the host asks, so that a break is sent.

Top module: `uart_xcvr`

## Requirements
- R1: After reset `txd` is 1, `tx_busy` is 0, `rx_valid` is 0 and all four status flags are 0.
- R2: A `tx_wr` pulse while the transmitter is idle and `tx_brk` is low makes `tx_busy` high and `txd` low (the start bit) from the next cycle. Each bit slot lasts 16 baud ticks, and a tick comes every `cfg_div+1` clocks.
- R3: `cfg_len` (5..9) sets the number of data bits. Bits of `tx_data` at or above that length are not sent, and the matching bits of `rx_data` read as 0.
- R4: If `cfg_msb` is 0, data bit 0 follows the start bit first. If `cfg_msb` is 1, bit `cfg_len-1` goes first. The receiver reassembles the bits in the same order.
- R5: `cfg_par` selects the parity bit that follows the last data bit: 0 none, 1 even (XOR of the data), 2 odd (inverted XOR), 3 always 0, 4 always 1.
- R6: `cfg_stop` selects the high stop period: 0 gives 16 ticks, 1 gives 24 ticks and 2 gives 32 ticks. `tx_busy` falls when the stop period ends, so with `cfg_div`=0 the frame lasts 16*(1+len+parity)+stop clocks.
- R7: A completed character loads `rx_data` and sets `rx_valid`. An `rx_rd` pulse clears `rx_valid`, and a newer character overwrites `rx_data`.
- R8: If a received parity bit does not match the selected mode, `err_par` is set and the character is still delivered.
- R9: If the first stop bit is sampled low and the character is not a break, `err_frame` is set and the character is still delivered.
- R10: If a character completes while `rx_valid` is still set and no read happens in that cycle, `err_ovr` is set.
- R11: While `tx_brk` is high and the transmitter is idle, `txd` stays low and `tx_busy` stays high. After `tx_brk` falls, `txd` returns high and `tx_busy` drops.
- R12: A received frame whose data bits, parity bit (if any) and stop bit are all low sets `brk_det` and does not set `rx_valid`.
- R13: The four status flags stay set until a `clr_status` pulse clears all of them. The clear wins over a set in the same cycle.
- R14: A `tx_wr` pulse while `tx_busy` is high (including during a break) is ignored, and no extra character goes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Baud divisor, one tick every cfg_div+1 clocks |
| cfg_len | input | 4 | Data bits per character, 5..9 |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop length code |
| cfg_msb | input | 1 | 1 selects most significant bit first |
| tx_wr | input | 1 | Write strobe for a transmit character |
| tx_data | input | 9 | Transmit character |
| tx_brk | input | 1 | Hold the line low (break) |
| tx_busy | output | 1 | Transmitter shifting or holding a break |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_rd | input | 1 | Read strobe, clears rx_valid |
| rx_valid | output | 1 | Unread character present |
| rx_data | output | 9 | Last received character |
| clr_status | input | 1 | Clears all status flags |
| err_par | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_ovr | output | 1 | Sticky overrun error |
| brk_det | output | 1 | Sticky break detected |

## Verification
The properties assume the configuration pins change only while both directions are idle, and that the host strobes are single-cycle pulses. The bench changes the format only after `tx_busy` has fallen and the receiver has delivered its character. It drives every strobe for exactly one cycle, between clock edges. Its own receive frames use exact 16-clock bit slots, each followed by an idle gap, so the receiver is never asked to resynchronise in the middle of a frame.

// File: rtl/uart_xcvr_pkg.sv
`timescale 1ns/1ps
package uart_xcvr_pkg;

    localparam int DW = 9;

    typedef enum logic [2:0] {
        PAR_NONE = 3'd0,
        PAR_EVEN = 3'd1,
        PAR_ODD  = 3'd2,
        PAR_ZERO = 3'd3,
        PAR_ONE  = 3'd4
    } par_mode_e;

    typedef enum logic [1:0] {
        STOP_ONE  = 2'd0,
        STOP_HALF = 2'd1,
        STOP_TWO  = 2'd2
    } stop_mode_e;

    typedef struct packed {
        logic [3:0] len;
        par_mode_e  par;
        stop_mode_e stop;
        logic       msb_first;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP, TX_BRK
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI
    } rx_state_e;

    // ones in the low len positions
    function automatic logic [DW-1:0] len_mask(input logic [3:0] len);
        logic [DW:0] one_hot;
        one_hot = '0;
        one_hot[len] = 1'b1;
        return DW'(one_hot - 1'b1);
    endfunction

    function automatic logic parity_of(input logic [DW-1:0] d, input par_mode_e m);
        case (m)
            PAR_EVEN: return ^d;
            PAR_ODD:  return ~^d;
            PAR_ONE:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    // data bit carried in slot i of the data field
    function automatic logic [3:0] slot_index(input logic [3:0] len, input logic msb_first,
                                              input logic [3:0] i);
        return msb_first ? (len - 4'd1 - i) : i;
    endfunction

endpackage

// File: rtl/uart_xcvr_baud.sv
`timescale 1ns/1ps
module uart_xcvr_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_reg_t;

    baud_reg_t q, d;

    always_comb begin
        tick = (q.cnt >= div);
        d = q;
        if (tick) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/uart_xcvr_tx.sv
`timescale 1ns/1ps
module uart_xcvr_tx
    import uart_xcvr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  frame_cfg_t    cfg,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          brk,
    output logic          busy,
    output logic          txd
);
    localparam int CW = $clog2(2 * OSR);
    localparam logic [CW-1:0] BIT_END  = CW'(OSR - 1);
    localparam logic [CW-1:0] HALF_END = CW'(OSR + OSR / 2 - 1);
    localparam logic [CW-1:0] TWO_END  = CW'(2 * OSR - 1);

    typedef struct packed {
        tx_state_e     state;
        logic [CW-1:0] cnt;
        logic [3:0]    slot;
        logic [DW-1:0] data;
        logic          par;
        logic          line;
    } tx_reg_t;

    tx_reg_t       q, d;
    logic [CW-1:0] end_cnt;
    logic          at_end;
    logic [DW-1:0] masked;

    always_comb begin
        end_cnt = BIT_END;
        if (q.state == TX_STOP) begin
            case (cfg.stop)
                STOP_HALF: end_cnt = HALF_END;
                STOP_TWO:  end_cnt = TWO_END;
                default:   end_cnt = BIT_END;
            endcase
        end
        at_end = tick && (q.cnt == end_cnt);
        masked = wdata & len_mask(cfg.len);

        d = q;
        case (q.state)
            TX_IDLE: begin
                d.line = 1'b1;
                d.cnt  = '0;
                if (brk) begin
                    d.state = TX_BRK;
                    d.line  = 1'b0;
                end else if (wr) begin
                    d.state = TX_START;
                    d.line  = 1'b0;
                    d.data  = masked;
                    d.par   = parity_of(masked, cfg.par);
                end
            end
            TX_BRK: begin
                d.line = 1'b0;
                if (!brk) begin
                    d.state = TX_IDLE;
                    d.line  = 1'b1;
                end
            end
            default: begin
                if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
                if (at_end) begin
                    d.cnt = '0;
                    case (q.state)
                        TX_START: begin
                            d.state = TX_DATA;
                            d.slot  = '0;
                            d.line  = q.data[slot_index(cfg.len, cfg.msb_first, 4'd0)];
                        end
                        TX_DATA: begin
                            if (q.slot == cfg.len - 4'd1) begin
                                if (cfg.par != PAR_NONE) begin
                                    d.state = TX_PAR;
                                    d.line  = q.par;
                                end else begin
                                    d.state = TX_STOP;
                                    d.line  = 1'b1;
                                end
                            end else begin
                                d.slot = q.slot + 4'd1;
                                d.line = q.data[slot_index(cfg.len, cfg.msb_first, q.slot + 4'd1)];
                            end
                        end
                        TX_PAR: begin
                            d.state = TX_STOP;
                            d.line  = 1'b1;
                        end
                        default: begin
                            d.state = TX_IDLE;
                            d.line  = 1'b1;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= TX_IDLE;
            q.cnt   <= '0;
            q.slot  <= '0;
            q.data  <= '0;
            q.par   <= 1'b0;
            q.line  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.state != TX_IDLE);
    assign txd  = q.line;
endmodule

// File: rtl/uart_xcvr_rx.sv
`timescale 1ns/1ps
module uart_xcvr_rx
    import uart_xcvr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  frame_cfg_t    cfg,
    input  logic          rxd,
    output logic          done,
    output logic          brk,
    output logic          perr,
    output logic          ferr,
    output logic [DW-1:0] dout
);
    localparam int SW = $clog2(OSR);
    localparam logic [SW-1:0] SAMP_A = SW'(OSR / 2 - 1);
    localparam logic [SW-1:0] SAMP_B = SW'(OSR / 2);
    localparam logic [SW-1:0] DECIDE = SW'(OSR / 2 + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        rx_state_e     state;
        logic [SW-1:0] cnt;
        logic [1:0]    samp;
        logic [3:0]    slot;
        logic [DW-1:0] data;
        logic          parv;
        logic          done;
        logic          brk;
        logic          perr;
        logic          ferr;
        logic [DW-1:0] dout;
    } rx_reg_t;

    rx_reg_t q, d;
    logic    vote;
    logic    is_break;

    always_comb begin
        vote = (q.samp[1] & q.samp[0]) | (q.samp[1] & q.s2) | (q.samp[0] & q.s2);
        is_break = (q.data == '0) && (cfg.par == PAR_NONE || !q.parv) && !vote;

        d      = q;
        d.s1   = rxd;
        d.s2   = q.s1;
        d.done = 1'b0;
        d.brk  = 1'b0;

        case (q.state)
            RX_IDLE: begin
                if (tick && !q.s2) begin
                    d.state = RX_START;
                    d.cnt   = SW'(1);
                end
            end
            RX_WAITHI: begin
                if (q.s2) begin
                    d.state = RX_IDLE;
                end
            end
            default: begin
                if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == SAMP_A) d.samp[1] = q.s2;
                    if (q.cnt == SAMP_B) d.samp[0] = q.s2;
                    if (q.cnt == DECIDE) begin
                        case (q.state)
                            RX_START: begin
                                if (vote) begin
                                    d.state = RX_IDLE;
                                end else begin
                                    d.state = RX_DATA;
                                    d.slot  = '0;
                                    d.data  = '0;
                                    d.parv  = 1'b0;
                                end
                            end
                            RX_DATA: begin
                                d.data[slot_index(cfg.len, cfg.msb_first, q.slot)] = vote;
                                if (q.slot == cfg.len - 4'd1) begin
                                    d.state = (cfg.par != PAR_NONE) ? RX_PAR : RX_STOP;
                                end else begin
                                    d.slot = q.slot + 4'd1;
                                end
                            end
                            RX_PAR: begin
                                d.parv  = vote;
                                d.state = RX_STOP;
                            end
                            default: begin
                                if (is_break) begin
                                    d.brk = 1'b1;
                                end else begin
                                    d.done = 1'b1;
                                    d.dout = q.data;
                                    d.perr = (cfg.par != PAR_NONE) &&
                                             (q.parv != parity_of(q.data, cfg.par));
                                    d.ferr = !vote;
                                end
                                d.state = vote ? RX_IDLE : RX_WAITHI;
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.s1    <= 1'b1;
            q.s2    <= 1'b1;
            q.state <= RX_IDLE;
            q.cnt   <= '0;
            q.samp  <= '0;
            q.slot  <= '0;
            q.data  <= '0;
            q.parv  <= 1'b0;
            q.done  <= 1'b0;
            q.brk   <= 1'b0;
            q.perr  <= 1'b0;
            q.ferr  <= 1'b0;
            q.dout  <= '0;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign brk  = q.brk;
    assign perr = q.perr;
    assign ferr = q.ferr;
    assign dout = q.dout;
endmodule

// File: rtl/uart_xcvr.sv
`timescale 1ns/1ps
module uart_xcvr
    import uart_xcvr_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OSR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [3:0]       cfg_len,
    input  logic [2:0]       cfg_par,
    input  logic [1:0]       cfg_stop,
    input  logic             cfg_msb,
    input  logic             tx_wr,
    input  logic [8:0]       tx_data,
    input  logic             tx_brk,
    output logic             tx_busy,
    output logic             txd,
    input  logic             rxd,
    input  logic             rx_rd,
    output logic             rx_valid,
    output logic [8:0]       rx_data,
    input  logic             clr_status,
    output logic             err_par,
    output logic             err_frame,
    output logic             err_ovr,
    output logic             brk_det
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
        logic          perr;
        logic          ferr;
        logic          ovr;
        logic          brk;
    } host_reg_t;

    frame_cfg_t    cfg;
    logic          tick;
    logic          rx_done;
    logic          rx_brk;
    logic          rx_perr;
    logic          rx_ferr;
    logic [DW-1:0] rx_dout;
    host_reg_t     q, d;

    always_comb begin
        cfg.len       = (cfg_len < 4'd5) ? 4'd5 : ((cfg_len > 4'd9) ? 4'd9 : cfg_len);
        cfg.par       = (cfg_par > 3'd4) ? PAR_NONE : par_mode_e'(cfg_par);
        cfg.stop      = (cfg_stop == 2'd3) ? STOP_TWO : stop_mode_e'(cfg_stop);
        cfg.msb_first = cfg_msb;
    end

    uart_xcvr_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (cfg_div),
        .tick  (tick)
    );

    uart_xcvr_tx #(.OSR(OSR)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cfg   (cfg),
        .wr    (tx_wr),
        .wdata (tx_data),
        .brk   (tx_brk),
        .busy  (tx_busy),
        .txd   (txd)
    );

    uart_xcvr_rx #(.OSR(OSR)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cfg   (cfg),
        .rxd   (rxd),
        .done  (rx_done),
        .brk   (rx_brk),
        .perr  (rx_perr),
        .ferr  (rx_ferr),
        .dout  (rx_dout)
    );

    always_comb begin
        d = q;
        if (rx_rd) begin
            d.valid = 1'b0;
        end
        if (rx_done) begin
            d.valid = 1'b1;
            d.data  = rx_dout;
            if (q.valid && !rx_rd) d.ovr = 1'b1;
            if (rx_perr) d.perr = 1'b1;
            if (rx_ferr) d.ferr = 1'b1;
        end
        if (rx_brk) begin
            d.brk = 1'b1;
        end
        if (clr_status) begin
            d.perr = 1'b0;
            d.ferr = 1'b0;
            d.ovr  = 1'b0;
            d.brk  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.valid <= 1'b0;
            q.data  <= '0;
            q.perr  <= 1'b0;
            q.ferr  <= 1'b0;
            q.ovr   <= 1'b0;
            q.brk   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rx_valid  = q.valid;
    assign rx_data   = q.data;
    assign err_par   = q.perr;
    assign err_frame = q.ferr;
    assign err_ovr   = q.ovr;
    assign brk_det   = q.brk;
endmodule

// File: rtl/uart_xcvr_chk.sv
`timescale 1ns/1ps
module uart_xcvr_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_wr,
    input logic tx_brk,
    input logic tx_busy,
    input logic txd,
    input logic rx_rd,
    input logic rx_valid,
    input logic rx_done,
    input logic rx_brk,
    input logic clr_status,
    input logic err_par,
    input logic err_frame,
    input logic err_ovr,
    input logic brk_det
);
    assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !tx_busy && !tx_brk) |=> (tx_busy && !txd));

    assert_break_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_brk && !tx_busy) |=> (tx_busy && !txd));

    assert_break_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_brk && $past(tx_brk) && tx_busy && !txd) |=> !txd);

    assert_done_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rx_valid);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_done) |=> !rx_valid);

    assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_valid && !rx_rd && !clr_status) |=> err_ovr);

    assert_break_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_brk && !clr_status) |=> brk_det);

    assert_break_no_char_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_brk |-> !rx_done);

    assert_clear_all_R13: assert property (@(posedge clk) disable iff (!rst_n)
        clr_status |=> (!err_par && !err_frame && !err_ovr && !brk_det));

    assert_par_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (err_par && !clr_status) |=> err_par);

    assert_frame_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame && !clr_status) |=> err_frame);

    assert_ovr_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovr && !clr_status) |=> err_ovr);

    assert_brk_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_det && !clr_status) |=> brk_det);
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_wr      (tx_wr),
    .tx_brk     (tx_brk),
    .tx_busy    (tx_busy),
    .txd        (txd),
    .rx_rd      (rx_rd),
    .rx_valid   (rx_valid),
    .rx_done    (rx_done),
    .rx_brk     (rx_brk),
    .clr_status (clr_status),
    .err_par    (err_par),
    .err_frame  (err_frame),
    .err_ovr    (err_ovr),
    .brk_det    (brk_det)
);

// File: tb/sim_uart_xcvr.sv
`timescale 1ns/1ps
module sim_uart_xcvr;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_div;
    logic [3:0]  cfg_len;
    logic [2:0]  cfg_par;
    logic [1:0]  cfg_stop;
    logic        cfg_msb;
    logic        tx_wr;
    logic [8:0]  tx_data;
    logic        tx_brk;
    logic        tx_busy;
    logic        txd;
    logic        rxd;
    logic        rx_rd;
    logic        rx_valid;
    logic [8:0]  rx_data;
    logic        clr_status;
    logic        err_par, err_frame, err_ovr, brk_det;
    logic        man_en, man_line;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    assign rxd = man_en ? man_line : txd;

    uart_xcvr u0 (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_par(cfg_par),
        .cfg_stop(cfg_stop), .cfg_msb(cfg_msb), .tx_wr(tx_wr), .tx_data(tx_data),
        .tx_brk(tx_brk), .tx_busy(tx_busy), .txd(txd), .rxd(rxd), .rx_rd(rx_rd),
        .rx_valid(rx_valid), .rx_data(rx_data), .clr_status(clr_status), .err_par(err_par),
        .err_frame(err_frame), .err_ovr(err_ovr), .brk_det(brk_det)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int par_of(input int dm, input int mode);
        int ones;
        ones = $countones(dm);
        case (mode)
            1: return ones % 2;
            2: return 1 - (ones % 2);
            4: return 1;
            default: return 0;
        endcase
    endfunction

    // expected line level in bit slot s of a frame
    function automatic int exp_line(input int d, input int len, input int mode, input int msb,
                                    input int s);
        int dm;
        dm = d & ((1 << len) - 1);
        if (s == 0) return 0;
        if (s <= len) return (dm >> (msb != 0 ? len - s : s - 1)) & 1;
        if (mode != 0 && s == len + 1) return par_of(dm, mode);
        return 1;
    endfunction

    function automatic int flags();
        return {28'd0, err_par, err_frame, err_ovr, brk_det};
    endfunction

    task automatic set_cfg(input int len, input int mode, input int stop, input int msb,
                           input int div);
        cfg_len  = 4'(len);
        cfg_par  = 3'(mode);
        cfg_stop = 2'(stop);
        cfg_msb  = 1'(msb);
        cfg_div  = 16'(div);
        @(negedge clk);
    endtask

    task automatic pulse_rd();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr_status = 1'b1;
        @(negedge clk);
        clr_status = 1'b0;
        @(negedge clk);
    endtask

    // called at a negedge; returns the start check, the received character and the busy length
    task automatic send_char(input int d, input int len, input int mode, input int msb,
                             input int div, output bit start_low, output bit got,
                             output int got_data, output int dur, output bit wave_ok);
        tx_data = 9'(d);
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr     = 1'b0;
        start_low = (txd == 1'b0) && tx_busy;
        got = 0; got_data = 0; dur = 0; wave_ok = 1;
        while (tx_busy && dur < 5000) begin
            if (div == 0 && (dur % 16) == 8) begin
                if (int'(txd) != exp_line(d, len, mode, msb, dur / 16)) wave_ok = 0;
            end
            if (rx_valid && !got) begin
                got = 1;
                got_data = int'(rx_data);
            end
            dur++;
            @(negedge clk);
        end
    endtask

    task automatic man_bit(input bit v);
        man_line = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic man_frame(input int d, input bit haspar, input bit pv, input bit stopv);
        man_bit(1'b0);
        for (int i = 0; i < 8; i++) man_bit(1'((d >> i) & 1));
        if (haspar) man_bit(pv);
        man_bit(stopv);
        man_line = 1'b1;
        repeat (32) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit sl, got, wok;
        int gd, dur;
        rst_n = 1'b0; tx_wr = 1'b0; tx_data = '0; tx_brk = 1'b0; rx_rd = 1'b0;
        clr_status = 1'b0; man_en = 1'b0; man_line = 1'b1;
        cfg_div = '0; cfg_len = 4'd8; cfg_par = '0; cfg_stop = '0; cfg_msb = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd && !tx_busy && !rx_valid && flags() == 0, "R1 reset",
            {txd, tx_busy, rx_valid, 4'(flags())}, 7'b1000000);

        // loopback sweep of every format with one tick per clock
        for (int len = 5; len <= 9; len++) begin
            for (int mode = 0; mode <= 4; mode++) begin
                for (int stop = 0; stop <= 2; stop++) begin
                    for (int msb = 0; msb <= 1; msb++) begin
                        set_cfg(len, mode, stop, msb, 0);
                        for (int c = 0; c < 2; c++) begin
                            int d, expd, expdur;
                            d = ((len * 30 + mode * 6 + stop * 2 + msb) * 53 + c * 170 + 'h1A5) & 'h1FF;
                            expd = d & ((1 << len) - 1);
                            expdur = 16 * (1 + len + (mode != 0 ? 1 : 0)) + 16 + 8 * stop;
                            send_char(d, len, mode, msb, 0, sl, got, gd, dur, wok);
                            if (c == 0) chk(sl, "R2 start bit", int'(sl), 1);
                            chk(got && gd == expd, "R3 data", gd, expd);
                            chk(wok, "R4 R5 line bits", int'(wok), 1);
                            chk(dur == expdur, "R6 frame length", dur, expdur);
                            chk(flags() == 0, "R8 R9 clean flags", flags(), 0);
                            pulse_rd();
                            chk(!rx_valid, "R7 read clears", int'(rx_valid), 0);
                        end
                    end
                end
            end
        end

        // slower divisor
        set_cfg(7, 2, 2, 1, 2);
        repeat (10) @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            int d;
            d = 'h2B + c * 'h31;
            send_char(d, 7, 2, 1, 2, sl, got, gd, dur, wok);
            chk(got && gd == (d & 'h7F), "R3 data div2", gd, d & 'h7F);
            chk(dur >= 525 && dur <= 531, "R2 bit time div2", dur, 528);
            pulse_rd();
        end

        // write while busy is ignored
        set_cfg(8, 0, 0, 0, 0);
        tx_data = 9'h03C; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        repeat (40) @(negedge clk);
        tx_data = 9'h1C3; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        while (tx_busy) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(rx_valid && rx_data == 9'h03C, "R14 first char only", int'(rx_data), 'h3C);
        pulse_rd();
        repeat (400) @(negedge clk);
        chk(!rx_valid && !tx_busy, "R14 no second char", int'(rx_valid), 0);

        // injected receive errors: 8 bits, even parity, LSB first
        set_cfg(8, 1, 0, 0, 0);
        man_en = 1'b1;
        man_frame('h55, 1, 1, 1);
        chk(rx_valid && rx_data == 9'h055, "R8 data kept", int'(rx_data), 'h55);
        chk(err_par && !err_frame, "R8 parity flag", flags(), 8);
        pulse_rd();
        repeat (100) @(negedge clk);
        chk(err_par, "R13 sticky", flags(), 8);
        pulse_clr();
        chk(flags() == 0, "R13 clear", flags(), 0);

        man_frame('h0F, 1, 0, 0);
        chk(rx_valid && rx_data == 9'h00F, "R9 data kept", int'(rx_data), 'hF);
        chk(err_frame && !err_par && !brk_det, "R9 frame flag", flags(), 4);
        pulse_rd();
        pulse_clr();

        man_frame('h33, 1, 0, 1);
        man_frame('h5A, 1, 0, 1);
        chk(err_ovr && rx_data == 9'h05A, "R10 overrun", {flags(), int'(rx_data)} , 'h25A);
        chk(rx_valid, "R7 newer char valid", int'(rx_valid), 1);
        pulse_rd();
        pulse_clr();

        man_frame('h00, 1, 0, 0);
        chk(brk_det && !rx_valid && !err_frame, "R12 break detect", flags(), 1);
        pulse_clr();
        chk(flags() == 0, "R13 clear break", flags(), 0);
        man_en = 1'b0;

        // transmitted break looped back
        tx_brk = 1'b1;
        @(negedge clk);
        chk(!txd && tx_busy, "R11 break low", int'(txd), 0);
        tx_data = 9'h0AA; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        repeat (250) @(negedge clk);
        chk(!txd && tx_busy, "R11 break held", int'(txd), 0);
        chk(brk_det && !rx_valid, "R12 looped break", flags(), 1);
        tx_brk = 1'b0;
        repeat (2) @(negedge clk);
        chk(txd && !tx_busy, "R11 break release", int'(txd), 1);
        repeat (300) @(negedge clk);
        chk(!rx_valid && !tx_busy, "R14 write during break", int'(rx_valid), 0);
        pulse_clr();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule